// File: doc/BRIEF.md
# Enclave Lifecycle Sequencer

This block tracks the lifecycle of a single protected enclave and decides whether each leaf-function command is allowed. A command has a privilege flag that selects between the kernel-level and user-level leaf tables, plus a 3-bit leaf code. The block decodes the leaf against the table for that privilege level and checks it against the current lifecycle state and page count. One cycle after each command it returns an accept or a fault.

Building the enclave follows a fixed order. A create command opens the enclave. Add-page and extend commands follow, then initialise, and then enter and exit cycles. An external interrupt can suspend a running enclave, and an interrupted-resume command restarts it. Remove commands reclaim pages, and the enclave returns to empty when the last page is removed.

An enclave created with the debug flag also allows 64-bit debug reads and writes to a small internal word buffer. Measurement, signature checks and key derivation are stubs: each takes one cycle and always succeeds. The report and get-key commands return zero data.

Top module: `enclave_lifecycle_seq`

## Requirements
- R1: After reset the state is EMPTY (code 0), the page count is 0, and rsp_valid is low. A reset asserted in the middle of a run restores the same values.
- R2: Each cycle with cmd_valid high produces exactly one cycle of rsp_valid high on the next cycle. In that cycle rsp_fault is 1 for a refused command and 0 for an accepted one. The state codes are EMPTY=0, BUILDING=1, READY=2, RUNNING=3 and INTERRUPTED=4.
- R3: Privileged leaf codes (cmd_priv=1) are: 0 create, 1 add page, 2 initialise, 3 remove, 4 debug read, 5 debug write, 6 extend. Create is accepted only in EMPTY. It moves the state to BUILDING, clears the page count and latches cmd_debug as the debug mode.
- R4: Add page is accepted only in BUILDING. It increments the page count, and it faults when the count already equals MAX_PAGES.
- R5: Extend and initialise are accepted only in BUILDING with a page count of at least 1. Initialise moves the state to READY, and extend leaves the state and count unchanged.
- R6: Unprivileged leaf codes (cmd_priv=0) are: 0 report, 1 get key, 2 enter, 3 interrupted resume, 4 exit. Enter moves READY to RUNNING, and exit moves RUNNING to READY.
- R7: irq high while the state is RUNNING moves the state to INTERRUPTED, and a command in that same cycle faults. Interrupted resume is accepted only in INTERRUPTED and moves the state back to RUNNING.
- R8: Report and get key are accepted only in RUNNING. When accepted they return rsp_rdata of zero.
- R9: Remove is accepted only in BUILDING or READY. If the page count is above 1 it decrements the count. Otherwise it clears the count, returns the state to EMPTY and clears the debug mode.
- R10: Debug read and debug write are accepted only when the debug mode is set and the state is not EMPTY. A write stores the 64-bit cmd_wdata at word cmd_addr. A read returns that word on rsp_rdata in the response cycle. A refused write leaves the buffer unchanged.
- R11: Any refused command, including privileged leaf 7 and unprivileged leaves 5 to 7, leaves the state and page count unchanged. rsp_rdata is zero for every response other than an accepted debug read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_priv | input | 1 | 1 selects the kernel-level leaf table, 0 the user-level table |
| cmd_leaf | input | 3 | Leaf code |
| cmd_debug | input | 1 | Debug-mode flag, used by create |
| cmd_addr | input | IDX_W | Word index for debug access |
| cmd_wdata | input | 64 | Debug write data |
| irq | input | 1 | External interrupt for a running enclave |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_fault | output | 1 | 1 means the command was refused |
| rsp_rdata | output | 64 | Debug read data, zero otherwise |
| state_o | output | 3 | Current lifecycle state code |
| page_cnt_o | output | CNT_W | Current number of added pages |

## Verification
The bench builds the block with MAX_PAGES=3 and WORDS=4, which gives a 2-bit page count and a 2-bit word index. With these values the page-count ceiling is reached after three add commands, so the add fault at full capacity is tested. The full walk down through three removes back to EMPTY also fits in a short table. The four-word buffer is small enough that a debug write in one enclave can be read back in a later debug enclave. This shows that a refused non-debug write left the stored word unchanged.

// File: rtl/enc_seq_pkg.sv
package enc_seq_pkg;

    localparam int unsigned LEAF_W = 3;
    localparam int unsigned DATA_W = 64;

    typedef enum logic [2:0] {
        ST_EMPTY       = 3'd0,
        ST_BUILDING    = 3'd1,
        ST_READY       = 3'd2,
        ST_RUNNING     = 3'd3,
        ST_INTERRUPTED = 3'd4
    } life_state_e;

    typedef enum logic [3:0] {
        OP_CREATE,
        OP_ADD,
        OP_INIT,
        OP_REMOVE,
        OP_DRD,
        OP_DWR,
        OP_EXTEND,
        OP_REPORT,
        OP_GETKEY,
        OP_ENTER,
        OP_RESUME,
        OP_EXIT,
        OP_BAD
    } op_e;

endpackage

// File: rtl/enc_leaf_decode.sv
module enc_leaf_decode
    import enc_seq_pkg::*;
(
    input  logic              priv,
    input  logic [LEAF_W-1:0] leaf,
    output op_e               op
);

    always_comb begin
        op = OP_BAD;
        if (priv) begin
            case (leaf)
                3'd0:    op = OP_CREATE;
                3'd1:    op = OP_ADD;
                3'd2:    op = OP_INIT;
                3'd3:    op = OP_REMOVE;
                3'd4:    op = OP_DRD;
                3'd5:    op = OP_DWR;
                3'd6:    op = OP_EXTEND;
                default: op = OP_BAD;
            endcase
        end else begin
            case (leaf)
                3'd0:    op = OP_REPORT;
                3'd1:    op = OP_GETKEY;
                3'd2:    op = OP_ENTER;
                3'd3:    op = OP_RESUME;
                3'd4:    op = OP_EXIT;
                default: op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/enc_lifecycle_fsm.sv
module enc_lifecycle_fsm
    import enc_seq_pkg::*;
#(
    parameter int unsigned MAX_PAGES = 8,
    parameter int unsigned CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  op_e              op,
    input  logic             cmd_debug,
    input  logic             irq,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output life_state_e      state,
    output logic [CNT_W-1:0] page_cnt
);

    typedef struct packed {
        life_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             dbg;
        logic             rsp_v;
        logic             rsp_f;
    } fsm_regs_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PAGES);

    fsm_regs_t q, d;
    logic      ok;
    logic      irq_take;

    always_comb begin
        d        = q;
        ok       = 1'b0;
        irq_take = irq && (q.st == ST_RUNNING);
        if (irq_take) begin
            d.st = ST_INTERRUPTED;
        end
        if (cmd_valid && !irq_take) begin
            case (op)
                OP_CREATE: if (q.st == ST_EMPTY) begin
                    ok    = 1'b1;
                    d.st  = ST_BUILDING;
                    d.cnt = '0;
                    d.dbg = cmd_debug;
                end
                OP_ADD: if (q.st == ST_BUILDING && q.cnt != CNT_MAX) begin
                    ok    = 1'b1;
                    d.cnt = q.cnt + CNT_ONE;
                end
                OP_EXTEND: if (q.st == ST_BUILDING && q.cnt != '0) begin
                    ok = 1'b1;
                end
                OP_INIT: if (q.st == ST_BUILDING && q.cnt != '0) begin
                    ok   = 1'b1;
                    d.st = ST_READY;
                end
                OP_REMOVE: if (q.st == ST_BUILDING || q.st == ST_READY) begin
                    ok = 1'b1;
                    if (q.cnt > CNT_ONE) begin
                        d.cnt = q.cnt - CNT_ONE;
                    end else begin
                        d.cnt = '0;
                        d.st  = ST_EMPTY;
                        d.dbg = 1'b0;
                    end
                end
                OP_DRD, OP_DWR: if (q.dbg && q.st != ST_EMPTY) begin
                    ok = 1'b1;
                end
                OP_REPORT, OP_GETKEY: if (q.st == ST_RUNNING) begin
                    ok = 1'b1;
                end
                OP_ENTER: if (q.st == ST_READY) begin
                    ok   = 1'b1;
                    d.st = ST_RUNNING;
                end
                OP_RESUME: if (q.st == ST_INTERRUPTED) begin
                    ok   = 1'b1;
                    d.st = ST_RUNNING;
                end
                OP_EXIT: if (q.st == ST_RUNNING) begin
                    ok   = 1'b1;
                    d.st = ST_READY;
                end
                default: ok = 1'b0;
            endcase
        end
        d.rsp_v = cmd_valid;
        d.rsp_f = cmd_valid && !ok;
        acc_rd  = ok && (op == OP_DRD);
        acc_wr  = ok && (op == OP_DWR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_EMPTY, cnt: '0, dbg: 1'b0, rsp_v: 1'b0, rsp_f: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign state     = q.st;
    assign page_cnt  = q.cnt;
    assign rsp_valid = q.rsp_v;
    assign rsp_fault = q.rsp_f;

    assert_resp_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (q.rsp_v && $past(rst_n)) || !$past(rst_n));

    assert_fault_has_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.rsp_f |-> q.rsp_v);

    assert_fault_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_f && !$past(irq)) |-> (q.st == $past(q.st) && q.cnt == $past(q.cnt)));

    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_MAX);

    assert_ready_has_pages_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READY) |-> (q.cnt != '0));

    assert_run_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUNNING && $past(q.st) != ST_RUNNING)
        |-> ($past(q.st) == ST_READY || $past(q.st) == ST_INTERRUPTED));

    assert_interrupt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_INTERRUPTED && $past(q.st) != ST_INTERRUPTED)
        |-> ($past(q.st) == ST_RUNNING && $past(irq)));

    assert_empty_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EMPTY) |-> (q.cnt == '0 && !q.dbg));

endmodule

// File: rtl/enc_dbg_buffer.sv
module enc_dbg_buffer #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [WORDS-1:0]  word_we;

    for (genvar w = 0; w < WORDS; w++) begin : g_word_sel
        assign word_we[w] = wr_en && (addr == IDX_W'(w));
    end

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = word_we[i] ? wdata : mem_q[i];
        end
        rdata_d = rd_en ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    assert_one_word_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_we));

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0) || !$past(rst_n));

endmodule

// File: rtl/enclave_lifecycle_seq.sv
module enclave_lifecycle_seq
    import enc_seq_pkg::*;
#(
    parameter  int unsigned MAX_PAGES = 8,
    parameter  int unsigned WORDS     = 8,
    localparam int unsigned CNT_W     = $clog2(MAX_PAGES + 1),
    localparam int unsigned IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_priv,
    input  logic [2:0]        cmd_leaf,
    input  logic              cmd_debug,
    input  logic [IDX_W-1:0]  cmd_addr,
    input  logic [63:0]       cmd_wdata,
    input  logic              irq,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [63:0]       rsp_rdata,
    output logic [2:0]        state_o,
    output logic [CNT_W-1:0]  page_cnt_o
);

    op_e         op;
    logic        acc_rd, acc_wr;
    life_state_e st;

    enc_leaf_decode i_decode (
        .priv (cmd_priv),
        .leaf (cmd_leaf),
        .op   (op)
    );

    enc_lifecycle_fsm #(
        .MAX_PAGES (MAX_PAGES),
        .CNT_W     (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .cmd_debug (cmd_debug),
        .irq       (irq),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .state     (st),
        .page_cnt  (page_cnt_o)
    );

    enc_dbg_buffer #(
        .WORDS  (WORDS),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) i_buffer (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (acc_rd),
        .wr_en (acc_wr),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .rdata (rsp_rdata)
    );

    assign state_o = st;

endmodule

// File: tb/test_enclave_lifecycle_seq.sv
module test_enclave_lifecycle_seq;

    localparam int unsigned MAX_PAGES = 3;
    localparam int unsigned WORDS     = 4;
    localparam int          NV        = 41;

    // layout: req[49:46] priv[45] leaf[44:42] dbg[41] addr[40:39] wdata[38:23] irq[22]
    //         fault[21] state[20:18] cnt[17:16] rdata[15:0]
    localparam logic [49:0] VECS [NV] = '{
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd0,2'd0,16'h0000}, // R9 remove in EMPTY
        {4'd6,  1'b0,3'd2,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd0,2'd0,16'h0000}, // R6 enter in EMPTY
        {4'd3,  1'b1,3'd0,1'b1,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd0,16'h0000}, // R3 create debug
        {4'd3,  1'b1,3'd0,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd0,16'h0000}, // R3 second create
        {4'd5,  1'b1,3'd6,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd0,16'h0000}, // R5 extend no pages
        {4'd5,  1'b1,3'd2,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd0,16'h0000}, // R5 init no pages
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd1,16'h0000}, // R4 add
        {4'd5,  1'b1,3'd6,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd1,16'h0000}, // R5 extend
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd2,16'h0000}, // R4 add
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd3,16'h0000}, // R4 add to max
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd3,16'h0000}, // R4 add at max
        {4'd10, 1'b1,3'd5,1'b0,2'd2,16'hBEEF,1'b0, 1'b0,3'd1,2'd3,16'h0000}, // R10 debug write
        {4'd10, 1'b1,3'd4,1'b0,2'd2,16'h0000,1'b0, 1'b0,3'd1,2'd3,16'hBEEF}, // R10 debug read
        {4'd11, 1'b1,3'd7,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd3,16'h0000}, // R11 priv leaf 7
        {4'd8,  1'b0,3'd0,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd1,2'd3,16'h0000}, // R8 report building
        {4'd5,  1'b1,3'd2,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd2,2'd3,16'h0000}, // R5 init
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd2,2'd3,16'h0000}, // R4 add in READY
        {4'd6,  1'b0,3'd4,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd2,2'd3,16'h0000}, // R6 exit in READY
        {4'd7,  1'b0,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd2,2'd3,16'h0000}, // R7 resume in READY
        {4'd6,  1'b0,3'd2,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd3,2'd3,16'h0000}, // R6 enter
        {4'd8,  1'b0,3'd0,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd3,2'd3,16'h0000}, // R8 report
        {4'd8,  1'b0,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd3,2'd3,16'h0000}, // R8 get key
        {4'd10, 1'b1,3'd4,1'b0,2'd2,16'h0000,1'b0, 1'b0,3'd3,2'd3,16'hBEEF}, // R10 read running
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd3,2'd3,16'h0000}, // R9 remove running
        {4'd11, 1'b0,3'd5,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd3,2'd3,16'h0000}, // R11 user leaf 5
        {4'd7,  1'b0,3'd2,1'b0,2'd0,16'h0000,1'b1, 1'b1,3'd4,2'd3,16'h0000}, // R7 irq with cmd
        {4'd8,  1'b0,3'd0,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd4,2'd3,16'h0000}, // R8 report interrupted
        {4'd6,  1'b0,3'd4,1'b0,2'd0,16'h0000,1'b0, 1'b1,3'd4,2'd3,16'h0000}, // R6 exit interrupted
        {4'd7,  1'b0,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd3,2'd3,16'h0000}, // R7 resume
        {4'd6,  1'b0,3'd4,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd2,2'd3,16'h0000}, // R6 exit
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd2,2'd2,16'h0000}, // R9 remove
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd2,2'd1,16'h0000}, // R9 remove
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd0,2'd0,16'h0000}, // R9 last remove
        {4'd10, 1'b1,3'd4,1'b0,2'd2,16'h0000,1'b0, 1'b1,3'd0,2'd0,16'h0000}, // R10 read in EMPTY
        {4'd3,  1'b1,3'd0,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd0,16'h0000}, // R3 create non-debug
        {4'd10, 1'b1,3'd5,1'b0,2'd2,16'h1234,1'b0, 1'b1,3'd1,2'd0,16'h0000}, // R10 write refused
        {4'd4,  1'b1,3'd1,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd1,16'h0000}, // R4 add
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd0,2'd0,16'h0000}, // R9 remove to EMPTY
        {4'd3,  1'b1,3'd0,1'b1,2'd0,16'h0000,1'b0, 1'b0,3'd1,2'd0,16'h0000}, // R3 create debug
        {4'd10, 1'b1,3'd4,1'b0,2'd2,16'h0000,1'b0, 1'b0,3'd1,2'd0,16'hBEEF}, // R10 word unchanged
        {4'd9,  1'b1,3'd3,1'b0,2'd0,16'h0000,1'b0, 1'b0,3'd0,2'd0,16'h0000}  // R9 remove at zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_priv = 1'b0;
    logic [2:0]  cmd_leaf = '0;
    logic        cmd_debug = 1'b0;
    logic [1:0]  cmd_addr = '0;
    logic [63:0] cmd_wdata = '0;
    logic        irq = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata;
    logic [2:0]  state_o;
    logic [1:0]  page_cnt_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    enclave_lifecycle_seq #(
        .MAX_PAGES (MAX_PAGES),
        .WORDS     (WORDS)
    ) i_enclave_lifecycle_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_priv   (cmd_priv),
        .cmd_leaf   (cmd_leaf),
        .cmd_debug  (cmd_debug),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .irq        (irq),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_rdata  (rsp_rdata),
        .state_o    (state_o),
        .page_cnt_o (page_cnt_o)
    );

    task automatic check_out(input string tag, input logic ev, input logic ef,
                             input logic [2:0] est, input logic [1:0] ecnt,
                             input logic [63:0] erd);
        checks++;
        if (rsp_valid !== ev || (ev && rsp_fault !== ef) || state_o !== est ||
            page_cnt_o !== ecnt || (ev && rsp_rdata !== erd)) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b st=%0d cnt=%0d rd=%h, expected v=%0b f=%0b st=%0d cnt=%0d rd=%h",
                     tag, rsp_valid, rsp_fault, state_o, page_cnt_o, rsp_rdata,
                     ev, ef, est, ecnt, erd);
        end
    endtask

    task automatic send(input logic p, input logic [2:0] lf, input logic dbg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_priv = p; cmd_leaf = lf; cmd_debug = dbg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_vec(input int idx);
        logic [49:0] v;
        v = VECS[idx];
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_priv  = v[45];
        cmd_leaf  = v[44:42];
        cmd_debug = v[41];
        cmd_addr  = v[40:39];
        cmd_wdata = {4{v[38:23]}};
        irq       = v[22];
        @(negedge clk);
        cmd_valid = 1'b0;
        irq       = 1'b0;
        check_out($sformatf("R%0d vector %0d", v[49:46], idx), 1'b1, v[21],
                  v[20:18], v[17:16], {4{v[15:0]}});
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset state", 1'b0, 1'b0, 3'd0, 2'd0, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_vec(i);
        end

        // R2: response lasts exactly one cycle
        @(negedge clk);
        check_out("R2 response single cycle", 1'b0, 1'b0, 3'd0, 2'd0, 64'h0);

        // R7: interrupt alone while running
        send(1'b1, 3'd0, 1'b0);
        send(1'b1, 3'd1, 1'b0);
        send(1'b1, 3'd2, 1'b0);
        send(1'b0, 3'd2, 1'b0);
        check_out("R6 enter directed", 1'b1, 1'b0, 3'd3, 2'd1, 64'h0);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check_out("R7 irq alone", 1'b0, 1'b0, 3'd4, 2'd1, 64'h0);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check_out("R7 irq ignored when interrupted", 1'b0, 1'b0, 3'd4, 2'd1, 64'h0);
        send(1'b0, 3'd3, 1'b0);
        check_out("R7 resume directed", 1'b1, 1'b0, 3'd3, 2'd1, 64'h0);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid-run reset", 1'b0, 1'b0, 3'd0, 2'd0, 64'h0);
        rst_n = 1'b1;
        send(1'b0, 3'd2, 1'b0);
        check_out("R6 enter after reset", 1'b1, 1'b1, 3'd0, 2'd0, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule